// File: doc/BRIEF.md
# Ancillary Packet Line Scheduler and Formatter

This block places one buffered ancillary data packet into a 525-line video word stream once per field and produces every word of that packet. A single 8-bit line setting selects the insertion line in both fields. In the first field the packet goes on the line one above the setting. In the second field it goes on the matching line 263 lines further on. Output begins when the horizontal word counter reaches a programmable start position.

The capture buffer ahead of this block holds only the 9-bit payload words. This block adds the rest: the ancillary flag, the data ID, bit 9 of every word, optional parity in bit 8, and the trailing checksum. Alongside the words it drives a valid strobe and a select for the downstream video multiplexer. The buffer is read as a show-ahead queue: the word at its head is visible, and a read strobe pops it.

Top module: `anc_pkt_inserter`

## Requirements
- R1: No packet is emitted in a field while `ins_enable` is low at the target line.
- R2: At most one packet is emitted per field, even when the target line number appears again within the same field.
- R3: In field 1 (`field_id` = 0) the packet is emitted on line `tgt_line` + 1.
- R4: In field 2 (`field_id` = 1) the packet is emitted on line `tgt_line` + 264.
- R5: `buf_ready` is sampled in the first cycle of the target line. If it is low at that point, the field is skipped, even if it rises later in that line.
- R6: The first words are the flag. With `comp_mode` = 1 they are 000h, 3FFh, 3FFh. With `comp_mode` = 0 there is a single word, 3FCh.
- R7: The word after the flag is the data ID. Bits 7:0 equal `data_id`, bit 8 is even parity over bits 7:0, and bit 9 is the inverse of bit 8.
- R8: Each buffered word follows in queue order. When `par_gen` = 1, bit 8 is replaced by even parity over bits 7:0; when `par_gen` = 0, bit 8 passes through unchanged. Bit 9 is always the inverse of bit 8.
- R9: The last word is the checksum: the 9-bit sum of the low 9 bits of the data ID word and of every payload word, with bit 9 the inverse of bit 8.
- R10: If `hpos` equals `start_pos` in cycle k of the target line, the first word appears in cycle k+1. `pkt_valid` then stays high for exactly flag length + `buf_count` + 2 consecutive cycles, and `mux_sel` equals `pkt_valid` in every cycle.
- R11: `buf_rd` is high in exactly one cycle per payload word: the cycle in which that word is on `pkt_word`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_enable | input | 1 | Global packet insertion enable |
| field_id | input | 1 | 0 = field 1, 1 = field 2 |
| line_num | input | 10 | Current video line number |
| hpos | input | 12 | Horizontal word position |
| tgt_line | input | 8 | Line setting (field-1 line minus one) |
| start_pos | input | 12 | Horizontal position that launches the packet |
| data_id | input | 8 | Packet data ID |
| comp_mode | input | 1 | 1 = component (three-word flag), 0 = composite (one-word flag) |
| par_gen | input | 1 | Generate payload bit-8 parity |
| buf_ready | input | 1 | Capture buffer holds a complete packet |
| buf_count | input | 8 | Number of buffered payload words |
| buf_rdata | input | 9 | Head word of the capture buffer |
| buf_rd | output | 1 | Pop the head word |
| pkt_word | output | 10 | Packet word out |
| pkt_valid | output | 1 | Packet word valid |
| mux_sel | output | 1 | Select packet path in the video mux |

## Verification
A wrong per-field arming state shows up as a missing, duplicated or misplaced packet. That fault is visible within the target line, as a wrong first-word line or offset, or as a second valid burst when the bench revisits the line. A corrupted sequencer index or latched count shows up as a wrong run length and a read count that does not match the queue. A bad checksum accumulator shows only in the final word of the packet. Randomised payloads, lengths, modes and parity settings expose each of these faults in the packet where it occurs.

// File: rtl/anc_pkg.sv
package anc_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_FLAG,
        S_DID,
        S_DATA,
        S_CSUM
    } fmt_state_e;

    localparam logic [9:0] FLAG_LO   = 10'h000;
    localparam logic [9:0] FLAG_HI   = 10'h3FF;
    localparam logic [9:0] FLAG_COMP = 10'h3FC;

    function automatic logic even_par(input logic [7:0] b);
        return ^b;
    endfunction

    // bit 9 is always the inverse of bit 8
    function automatic logic [9:0] seal(input logic [8:0] w);
        return {~w[8], w};
    endfunction

    function automatic logic [9:0] flag_word(input logic comp, input logic first);
        if (!comp)
            return FLAG_COMP;
        return first ? FLAG_LO : FLAG_HI;
    endfunction

endpackage

// File: rtl/anc_line_gate.sv
module anc_line_gate #(
    parameter int LINE_W  = 10,
    parameter int HPOS_W  = 12,
    parameter int F2_OFS  = 263
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_enable,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_num,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [7:0]        tgt_line,
    input  logic [HPOS_W-1:0] start_pos,
    input  logic              buf_ready,
    input  logic              busy,
    output logic              start
);

    logic [LINE_W-1:0] prev_line;
    logic              prev_field;
    logic              done;
    logic              armed;
    logic [LINE_W-1:0] target;
    logic              on_target;
    logic              line_start;
    logic              field_chg;

    always_comb begin
        target = LINE_W'(tgt_line) + LINE_W'(1);
        if (field_id)
            target = target + LINE_W'(F2_OFS);
    end

    assign on_target  = (line_num == target);
    assign line_start = (line_num != prev_line);
    assign field_chg  = (field_id != prev_field);
    assign start      = armed && !busy && ins_enable && on_target &&
                        (hpos == start_pos) && !field_chg;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_line  <= '1;
            prev_field <= 1'b0;
            done       <= 1'b0;
            armed      <= 1'b0;
        end else begin
            prev_line  <= line_num;
            prev_field <= field_id;
            if (field_chg) begin
                done  <= 1'b0;
                armed <= 1'b0;
            end else if (start) begin
                armed <= 1'b0;
                done  <= 1'b1;
            end else if (line_start) begin
                armed <= on_target && !done && ins_enable && buf_ready;
                if (on_target)
                    done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/anc_pkt_fmt.sv
module anc_pkt_fmt
    import anc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             comp_mode,
    input  logic [7:0]       data_id,
    input  logic             par_gen,
    input  logic [CNT_W-1:0] buf_count,
    input  logic [8:0]       buf_rdata,
    output logic             buf_rd,
    output logic [9:0]       pkt_word,
    output logic             pkt_valid,
    output fmt_state_e       st_out
);

    fmt_state_e       st;
    logic [CNT_W-1:0] idx;
    logic [CNT_W-1:0] cnt;
    logic             comp_l;
    logic             par_l;
    logic [7:0]       did_l;
    logic [8:0]       csum;
    logic [8:0]       did9;
    logic [8:0]       data9;
    logic [CNT_W-1:0] flag_last;

    assign did9      = {even_par(did_l), did_l};
    assign data9     = par_l ? {even_par(buf_rdata[7:0]), buf_rdata[7:0]} : buf_rdata;
    assign flag_last = comp_l ? CNT_W'(2) : '0;

    always_comb begin
        case (st)
            S_FLAG:  pkt_word = flag_word(comp_l, idx == '0);
            S_DID:   pkt_word = seal(did9);
            S_DATA:  pkt_word = seal(data9);
            S_CSUM:  pkt_word = seal(csum);
            default: pkt_word = '0;
        endcase
    end

    assign pkt_valid = (st != S_IDLE);
    assign buf_rd    = (st == S_DATA);
    assign st_out    = st;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            idx    <= '0;
            cnt    <= '0;
            comp_l <= 1'b0;
            par_l  <= 1'b0;
            did_l  <= '0;
            csum   <= '0;
        end else begin
            case (st)
                S_IDLE: begin
                    if (start) begin
                        st     <= S_FLAG;
                        idx    <= '0;
                        cnt    <= buf_count;
                        comp_l <= comp_mode;
                        par_l  <= par_gen;
                        did_l  <= data_id;
                    end
                end
                S_FLAG: begin
                    if (idx == flag_last) begin
                        st  <= S_DID;
                        idx <= '0;
                    end else begin
                        idx <= idx + CNT_W'(1);
                    end
                end
                S_DID: begin
                    csum <= did9;
                    st   <= (cnt == '0) ? S_CSUM : S_DATA;
                end
                S_DATA: begin
                    csum <= csum + data9;
                    if (idx == cnt - CNT_W'(1))
                        st <= S_CSUM;
                    else
                        idx <= idx + CNT_W'(1);
                end
                S_CSUM:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/anc_pkt_inserter.sv
module anc_pkt_inserter
    import anc_pkg::*;
#(
    parameter int LINE_W      = 10,
    parameter int HPOS_W      = 12,
    parameter int CNT_W       = 8,
    parameter int F2_LINE_OFS = 263
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_enable,
    input  logic              field_id,
    input  logic [LINE_W-1:0] line_num,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [7:0]        tgt_line,
    input  logic [HPOS_W-1:0] start_pos,
    input  logic [7:0]        data_id,
    input  logic              comp_mode,
    input  logic              par_gen,
    input  logic              buf_ready,
    input  logic [CNT_W-1:0]  buf_count,
    input  logic [8:0]        buf_rdata,
    output logic              buf_rd,
    output logic [9:0]        pkt_word,
    output logic              pkt_valid,
    output logic              mux_sel
);

    logic       start;
    fmt_state_e fmt_st;

    anc_line_gate #(
        .LINE_W (LINE_W),
        .HPOS_W (HPOS_W),
        .F2_OFS (F2_LINE_OFS)
    ) u_gate (
        .clk        (clk),
        .rst        (rst),
        .ins_enable (ins_enable),
        .field_id   (field_id),
        .line_num   (line_num),
        .hpos       (hpos),
        .tgt_line   (tgt_line),
        .start_pos  (start_pos),
        .buf_ready  (buf_ready),
        .busy       (pkt_valid),
        .start      (start)
    );

    anc_pkt_fmt #(
        .CNT_W (CNT_W)
    ) u_fmt (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .comp_mode (comp_mode),
        .data_id   (data_id),
        .par_gen   (par_gen),
        .buf_count (buf_count),
        .buf_rdata (buf_rdata),
        .buf_rd    (buf_rd),
        .pkt_word  (pkt_word),
        .pkt_valid (pkt_valid),
        .st_out    (fmt_st)
    );

    assign mux_sel = pkt_valid;

endmodule

// File: rtl/anc_pkt_checker.sv
module anc_pkt_checker
    import anc_pkg::*;
#(
    parameter int HPOS_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              ins_enable,
    input logic              field_id,
    input logic [HPOS_W-1:0] hpos,
    input logic [HPOS_W-1:0] start_pos,
    input logic              pkt_valid,
    input logic [9:0]        pkt_word,
    input logic              buf_rd,
    input fmt_state_e        st
);

    logic       prev_f;
    logic       prev_v;
    logic [1:0] pkts;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_f <= 1'b0;
            prev_v <= 1'b0;
            pkts   <= '0;
        end else begin
            prev_f <= field_id;
            prev_v <= pkt_valid;
            if (field_id != prev_f)
                pkts <= '0;
            else if (pkt_valid && !prev_v && pkts != 2'd3)
                pkts <= pkts + 2'd1;
        end
    end

    p_no_start_disabled_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_valid) |-> $past(ins_enable));

    p_one_per_field_r2: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !prev_v && field_id == prev_f) |-> pkts == 2'd0);

    p_flag_first_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_valid) |-> (pkt_word == FLAG_LO || pkt_word == FLAG_COMP));

    p_bit9_inv_r7: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && st != S_FLAG) |-> (pkt_word[9] != pkt_word[8]));

    p_csum_last_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pkt_valid) |-> $past(st) == S_CSUM);

    p_start_pos_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(pkt_valid) |-> $past(hpos) == $past(start_pos));

    p_read_in_pkt_r11: assert property (@(posedge clk) disable iff (rst)
        buf_rd |-> pkt_valid);

endmodule

bind anc_pkt_inserter anc_pkt_checker #(.HPOS_W(HPOS_W)) i_chk (
    .clk        (clk),
    .rst        (rst),
    .ins_enable (ins_enable),
    .field_id   (field_id),
    .hpos       (hpos),
    .start_pos  (start_pos),
    .pkt_valid  (pkt_valid),
    .pkt_word   (pkt_word),
    .buf_rd     (buf_rd),
    .st         (fmt_st)
);

// File: tb/test_anc_pkt_inserter.sv
module test_anc_pkt_inserter;

    localparam int LINE_LEN = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        ins_enable;
    logic        field_id;
    logic [9:0]  line_num;
    logic [11:0] hpos;
    logic [7:0]  tgt_line;
    logic [11:0] start_pos;
    logic [7:0]  data_id;
    logic        comp_mode;
    logic        par_gen;
    logic        buf_ready;
    logic [7:0]  buf_count;
    logic [8:0]  buf_rdata;
    logic        buf_rd;
    logic [9:0]  pkt_word;
    logic        pkt_valid;
    logic        mux_sel;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    anc_pkt_inserter i_anc_pkt_inserter (
        .clk(clk), .rst(rst), .ins_enable(ins_enable), .field_id(field_id),
        .line_num(line_num), .hpos(hpos), .tgt_line(tgt_line),
        .start_pos(start_pos), .data_id(data_id), .comp_mode(comp_mode),
        .par_gen(par_gen), .buf_ready(buf_ready), .buf_count(buf_count),
        .buf_rdata(buf_rdata), .buf_rd(buf_rd), .pkt_word(pkt_word),
        .pkt_valid(pkt_valid), .mux_sel(mux_sel)
    );

    // show-ahead queue model
    logic [8:0] mem [0:255];
    logic [7:0] rd_ptr;
    logic       cap_clr;
    assign buf_rdata = mem[rd_ptr];

    always @(posedge clk) begin
        if (cap_clr)     rd_ptr <= '0;
        else if (buf_rd) rd_ptr <= rd_ptr + 8'd1;
    end

    // output capture
    logic [9:0] cap [0:299];
    int cap_n, rises, rd_n, mux_bad, first_l, first_h;
    logic prev_v;

    always @(negedge clk) begin
        if (cap_clr) begin
            cap_n = 0; rises = 0; rd_n = 0; mux_bad = 0;
            first_l = -1; first_h = -1; prev_v = 1'b0;
        end else begin
            if (mux_sel !== pkt_valid) mux_bad++;
            if (pkt_valid === 1'b1) begin
                if (!prev_v) begin
                    if (rises == 0) begin
                        first_l = int'(line_num);
                        first_h = int'(hpos);
                    end
                    rises++;
                end
                if (cap_n < 300) cap[cap_n] = pkt_word;
                cap_n++;
            end
            if (buf_rd === 1'b1) rd_n++;
            prev_v = (pkt_valid === 1'b1);
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [9:0] seal9(input logic [8:0] w);
        return {~w[8], w};
    endfunction

    task automatic drive_line(input logic f, input int l, input bit late);
        for (int h = 0; h < LINE_LEN; h++) begin
            @(posedge clk); #1;
            field_id = f;
            line_num = 10'(l);
            hpos     = 12'(h);
            if (late && h == 2) buf_ready = 1'b1;
        end
    endtask

    task automatic run_case(input logic f, input logic c, input logic p,
                            input logic en, input logic rdy, input bit late,
                            input int n, input int sp, input bit expect_pkt);
        logic [9:0] expw [0:299];
        logic [8:0] sum;
        logic [8:0] w9;
        int fl, k, tl;
        comp_mode  = c;
        par_gen    = p;
        ins_enable = en;
        tgt_line   = 8'($urandom_range(10, 200));
        data_id    = 8'($urandom_range(0, 255));
        start_pos  = 12'(sp);
        buf_count  = 8'(n);
        for (int i = 0; i < 256; i++) mem[i] = 9'($urandom_range(0, 511));
        buf_ready  = late ? 1'b0 : rdy;
        // leave the field and come back so the field state rearms
        @(posedge clk); #1;
        cap_clr = 1'b1; field_id = ~f; line_num = 10'd0; hpos = 12'd0;
        @(posedge clk); #1;
        cap_clr = 1'b0;
        tl = int'(tgt_line) + 1 + (f ? 263 : 0);
        drive_line(f, tl - 1, 1'b0);
        drive_line(f, tl, late);
        drive_line(f, tl + 1, 1'b0);
        drive_line(f, tl, 1'b0);         // revisit target line (R2)
        drive_line(f, tl + 2, 1'b0);
        if (!expect_pkt) begin
            chk(cap_n == 0, en ? "R5 skip" : "R1 disabled", cap_n, 0);
            chk(rd_n == 0, en ? "R5 no reads" : "R1 no reads", rd_n, 0);
            return;
        end
        // expected words
        fl = c ? 3 : 1;
        k = 0;
        if (c) begin
            expw[0] = 10'h000; expw[1] = 10'h3FF; expw[2] = 10'h3FF; k = 3;
        end else begin
            expw[0] = 10'h3FC; k = 1;
        end
        sum = {^data_id, data_id};
        expw[k] = seal9(sum); k++;
        for (int i = 0; i < n; i++) begin
            w9 = p ? {^mem[i][7:0], mem[i][7:0]} : mem[i];
            sum = sum + w9;
            expw[k] = seal9(w9); k++;
        end
        expw[k] = seal9(sum); k++;
        chk(cap_n == k, "R10 valid length", cap_n, k);
        chk(rises == 1, "R2 one packet per field", rises, 1);
        chk(first_l == tl, f ? "R4 field-2 line" : "R3 field-1 line", first_l, tl);
        chk(first_h == sp + 1, "R10 start offset", first_h, sp + 1);
        chk(mux_bad == 0, "R10 mux_sel tracks valid", mux_bad, 0);
        chk(rd_n == n, "R11 read count", rd_n, n);
        if (cap_n == k) begin
            for (int i = 0; i < k; i++) begin
                if (i < fl)
                    chk(cap[i] == expw[i], "R6 flag word", int'(cap[i]), int'(expw[i]));
                else if (i == fl)
                    chk(cap[i] == expw[i], "R7 data id word", int'(cap[i]), int'(expw[i]));
                else if (i == k - 1)
                    chk(cap[i] == expw[i], "R9 checksum", int'(cap[i]), int'(expw[i]));
                else
                    chk(cap[i] == expw[i], "R8 payload word", int'(cap[i]), int'(expw[i]));
            end
        end
    endtask

    initial begin
        #(8 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1'b1; cap_clr = 1'b1;
        ins_enable = 1'b0; field_id = 1'b0; line_num = 10'd0; hpos = 12'd0;
        tgt_line = 8'd0; start_pos = 12'd0; data_id = 8'd0; comp_mode = 1'b0;
        par_gen = 1'b0; buf_ready = 1'b0; buf_count = 8'd0;
        for (int i = 0; i < 256; i++) mem[i] = 9'd0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(pkt_valid == 1'b0, "R10 reset valid", int'(pkt_valid), 0);
        chk(mux_sel == 1'b0, "R10 reset mux_sel", int'(mux_sel), 0);
        chk(buf_rd == 1'b0, "R11 reset read", int'(buf_rd), 0);

        // directed corners
        run_case(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 5, 4, 1'b1);   // R3 R6 component
        run_case(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 3, 7, 1'b1);   // R4 composite, bit 8 passed
        run_case(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 0, 3, 1'b1);   // R9 empty payload
        run_case(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 0, 12, 1'b1);  // R9 composite empty
        run_case(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 4, 5, 1'b0);   // R1 disabled
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 4, 5, 1'b0);   // R5 not ready
        run_case(1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 4, 6, 1'b0);   // R5 ready too late
        run_case(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 40, 15, 1'b1); // R11 long packet

        // constrained random
        for (int t = 0; t < 16; t++) begin
            run_case(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'b1, 1'b1, 1'b0,
                     int'($urandom_range(0, 40)), int'($urandom_range(3, 15)), 1'b1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule